// File: doc/BRIEF.md
# Register File Self-Test Harness with Pseudo-Random Stimulus

This block wraps a 32-word by 8-bit register file with a built-in self-test. A single start pulse runs a write pass and then a readback pass. No stimulus comes from outside the block. Two five-stage shift-register generators with feedback produce the test addresses and the test data. Both step on the same clock and step together. Each generator cycles through 31 nonzero states, so it never visits address 0. An extra step after each pass writes address 0 with a fixed pattern and then checks it.

For readback, both generators are returned to their seeds and replayed. This regenerates every address with its expected data word. A compare stage, lined up with the one-cycle read latency of the register file, counts mismatching words in a saturating counter and sets a sticky fail flag. A retention-check start skips the write pass and only verifies the current contents against the replayed sequence. When the harness is idle, a normal-mode port gives external logic direct write and read access to the register file.

Top module: `rf_bist_top`

## Requirements
- R1: After reset, `done`, `fail` and `err_count` are all 0.
- R2: Addresses come from a 5-bit generator seeded with `ADDR_SEED` (0x01). On each step the register shifts left by one, and the new bit 0 is the XOR of bits 4 and 2. The data generator uses the same update with seed `DATA_SEED` (0x13). Its 3-bit history starts at 0 and shifts left on each step, taking in the old state bit 4 at bit 0. At step k the write pass stores the word {data state[4:0], history[2:0]} (state in bits 7:3) at the address state of step k, for k = 0..30.
- R3: The write pass stores `ZERO_PAT` (0xA5) at address 0.
- R4: A full test on an undisturbed register file ends with `done`=1, `fail`=0 and `err_count`=0.
- R5: A start with `chk_only`=1 performs only the readback pass. Each of the 32 words that differs from its expected value adds one to `err_count`.
- R6: `err_count` saturates at 2^ERR_W-1 (15 by default).
- R7: `fail` is set by any mismatch and stays set. An accepted start clears `done`, `fail` and `err_count` on the edge that accepts it.
- R8: While idle, `ext_we` writes `ext_wdata` to `ext_waddr`. `rdata` shows the word at `ext_raddr` one clock edge later.
- R9: While a test runs, `start`, `chk_only` and the external write inputs are ignored.
- R10: For the edge that samples `start`, `done` rises 65 edges later for a full test and 33 edges later for a check-only run. `done` is 0 while the test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a test when idle |
| chk_only | input | 1 | Sampled with start: 1 skips the write pass |
| ext_we | input | 1 | Normal-mode write enable |
| ext_waddr | input | 5 | Normal-mode write address |
| ext_wdata | input | 8 | Normal-mode write data |
| ext_raddr | input | 5 | Normal-mode read address |
| rdata | output | 8 | Registered read data of the register file |
| done | output | 1 | Test finished; held until the next start |
| fail | output | 1 | Sticky mismatch flag |
| err_count | output | ERR_W | Saturating mismatch count |

## Verification
A full test followed by a dump of all 32 words through the normal port checks that the generators visit each nonzero address once, with the right data words, and that the zero-address pattern is stored. Check-only runs are tried on three patterns: clean contents, which must give no errors; three corrupted words including address 0, which must give an exact count and separate per-word counting from a plain flag; and every word corrupted, which tells saturation apart from wraparound. A write and a restart request injected in the middle of a run show whether the harness blocks external access, through the final memory dump and through the exact cycle on which `done` rises.

// File: rtl/rf_bist_pkg.sv
package rf_bist_pkg;
  localparam int RF_AW     = 5;
  localparam int RF_DW     = 8;
  localparam int HIST_W    = RF_DW - RF_AW;
  localparam int RF_DEPTH  = 1 << RF_AW;
  localparam int LFSR_TAP  = 2;
  localparam int STEP_LAST = RF_DEPTH - 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_WR0, ST_RD, ST_RD0, ST_FIN
  } bist_st_e;

  function automatic logic [RF_AW-1:0] lfsr_adv(input logic [RF_AW-1:0] s);
    return {s[RF_AW-2:0], s[RF_AW-1] ^ s[LFSR_TAP]};
  endfunction
endpackage

// File: rtl/rf_bist_lfsr.sv
module rf_bist_lfsr
  import rf_bist_pkg::*;
#(
  parameter logic [RF_AW-1:0] SEED = 5'h01,
  parameter int H = 0,
  localparam int OW = RF_AW + H
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [RF_AW-1:0] state,
  output logic [OW-1:0]    word
);
  logic [RF_AW-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (load)      state_d = SEED;
    else if (step) state_d = lfsr_adv(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  generate
    if (H > 0) begin : g_hist
      logic [H-1:0] hist_q, hist_d;
      always_comb begin
        hist_d = hist_q;
        if (load)      hist_d = '0;
        else if (step) hist_d = H'({hist_q, state_q[RF_AW-1]});
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
      end
      assign word = {state_q, hist_q};
    end else begin : g_plain
      assign word = state_q;
    end
  endgenerate
endmodule

// File: rtl/rf_bist_regfile.sv
module rf_bist_regfile
  import rf_bist_pkg::*;
(
  input  logic             clk,
  input  logic             we,
  input  logic [RF_AW-1:0] waddr,
  input  logic [RF_DW-1:0] wdata,
  input  logic [RF_AW-1:0] raddr,
  output logic [RF_DW-1:0] rdata
);
  logic [RF_DW-1:0] mem [RF_DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rf_bist_ctrl.sv
module rf_bist_ctrl
  import rf_bist_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic chk_only,
  output logic running,
  output logic accept,
  output logic lfsr_load,
  output logic lfsr_step,
  output logic bist_we,
  output logic use_zero,
  output logic rd_req,
  output logic done
);
  bist_st_e st_q, st_d;
  logic [RF_AW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic at_last;

  assign at_last = (cnt_q == RF_AW'(STEP_LAST));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = chk_only ? ST_RD : ST_WR;
      ST_WR:   if (at_last) st_d = ST_WR0;
      ST_WR0:  st_d = ST_RD;
      ST_RD:   if (at_last) st_d = ST_RD0;
      ST_RD0:  st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign running   = (st_q != ST_IDLE);
  assign accept    = (st_q == ST_IDLE) && start;
  assign lfsr_load = accept || (st_q == ST_WR0);
  assign lfsr_step = (st_q == ST_WR) || (st_q == ST_RD);
  assign bist_we   = (st_q == ST_WR) || (st_q == ST_WR0);
  assign use_zero  = (st_q == ST_WR0) || (st_q == ST_RD0);
  assign rd_req    = (st_q == ST_RD) || (st_q == ST_RD0);

  always_comb begin
    cnt_d = cnt_q;
    if (lfsr_load)      cnt_d = '0;
    else if (lfsr_step) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    done_d = done_q;
    if (accept)               done_d = 1'b0;
    else if (st_q == ST_FIN)  done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/rf_bist_match.sv
module rf_bist_match
  import rf_bist_pkg::*;
#(
  parameter int ERR_W = 4,
  localparam logic [ERR_W-1:0] ERR_MAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             chk_req,
  input  logic [RF_DW-1:0] chk_exp,
  input  logic [RF_DW-1:0] rdata,
  output logic             fail,
  output logic [ERR_W-1:0] err_count
);
  logic             vld_q;
  logic [RF_DW-1:0] exp_q, exp_d;
  logic             fail_q, fail_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             miss;

  assign exp_d = chk_req ? chk_exp : exp_q;
  assign miss  = vld_q && (rdata != exp_q);

  always_comb begin
    fail_d = fail_q;
    err_d  = err_q;
    if (clear) begin
      fail_d = 1'b0;
      err_d  = '0;
    end else if (miss) begin
      fail_d = 1'b1;
      if (err_q != ERR_MAX) err_d = err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      exp_q  <= '0;
      fail_q <= 1'b0;
      err_q  <= '0;
    end else begin
      vld_q  <= chk_req;
      exp_q  <= exp_d;
      fail_q <= fail_d;
      err_q  <= err_d;
    end
  end

  assign fail      = fail_q;
  assign err_count = err_q;
endmodule

// File: rtl/rf_bist_top.sv
module rf_bist_top
  import rf_bist_pkg::*;
#(
  parameter int ERR_W = 4,
  parameter logic [RF_AW-1:0] ADDR_SEED = 5'h01,
  parameter logic [RF_AW-1:0] DATA_SEED = 5'h13,
  parameter logic [RF_DW-1:0] ZERO_PAT  = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             chk_only,
  input  logic             ext_we,
  input  logic [RF_AW-1:0] ext_waddr,
  input  logic [RF_DW-1:0] ext_wdata,
  input  logic [RF_AW-1:0] ext_raddr,
  output logic [RF_DW-1:0] rdata,
  output logic             done,
  output logic             fail,
  output logic [ERR_W-1:0] err_count
);
  logic running, accept, lfsr_load, lfsr_step, bist_we, use_zero, rd_req;
  logic [RF_AW-1:0] a_state, a_word, d_state;
  logic [RF_DW-1:0] d_word;
  logic [RF_AW-1:0] bist_addr;
  logic [RF_DW-1:0] bist_data;
  logic             rf_we;
  logic [RF_AW-1:0] rf_waddr, rf_raddr;
  logic [RF_DW-1:0] rf_wdata;

  rf_bist_ctrl u_ctrl (
    .clk, .rst_n, .start, .chk_only,
    .running, .accept, .lfsr_load, .lfsr_step,
    .bist_we, .use_zero, .rd_req, .done
  );

  rf_bist_lfsr #(.SEED(ADDR_SEED), .H(0)) u_alfsr (
    .clk, .rst_n, .load(lfsr_load), .step(lfsr_step),
    .state(a_state), .word(a_word)
  );

  rf_bist_lfsr #(.SEED(DATA_SEED), .H(HIST_W)) u_dlfsr (
    .clk, .rst_n, .load(lfsr_load), .step(lfsr_step),
    .state(d_state), .word(d_word)
  );

  assign bist_addr = use_zero ? '0 : a_word;
  assign bist_data = use_zero ? ZERO_PAT : d_word;

  assign rf_we    = running ? bist_we   : ext_we;
  assign rf_waddr = running ? bist_addr : ext_waddr;
  assign rf_wdata = running ? bist_data : ext_wdata;
  assign rf_raddr = running ? bist_addr : ext_raddr;

  rf_bist_regfile u_rf (
    .clk, .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata
  );

  rf_bist_match #(.ERR_W(ERR_W)) u_match (
    .clk, .rst_n, .clear(accept), .chk_req(rd_req),
    .chk_exp(bist_data), .rdata, .fail, .err_count
  );

  logic unused_dstate;
  assign unused_dstate = ^d_state;
endmodule

// File: rtl/rf_bist_chk.sv
module rf_bist_chk
  import rf_bist_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             running,
  input logic             done,
  input logic             fail,
  input logic [ERR_W-1:0] err_count,
  input logic [RF_AW-1:0] a_state
);
  logic restart;
  assign restart = start && !running;

  AST_ADDR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    a_state != '0); // R2

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !restart) |=> fail); // R7

  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == {ERR_W{1'b1}}) && !restart) |=> (err_count == {ERR_W{1'b1}})); // R6

  AST_ERR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (err_count >= $past(err_count))); // R5

  AST_DONE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (err_count != '0))); // R4

  AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !done); // R10
endmodule

bind rf_bist_top rf_bist_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running),
  .done(done), .fail(fail), .err_count(err_count), .a_state(a_state)
);

// File: tb/test_rf_bist_top.sv
module test_rf_bist_top;
  logic       clk = 1'b0;
  logic       rst_n, start, chk_only, ext_we;
  logic [4:0] ext_waddr, ext_raddr;
  logic [7:0] ext_wdata, rdata;
  logic       done, fail;
  logic [3:0] err_count;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [32];

  always #2.5 clk = ~clk;

  rf_bist_top i_rf_bist_top (
    .clk, .rst_n, .start, .chk_only, .ext_we, .ext_waddr, .ext_wdata,
    .ext_raddr, .rdata, .done, .fail, .err_count
  );

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic build_model();
    logic [4:0] sa = 5'h01;
    logic [4:0] sd = 5'h13;
    logic [2:0] h  = 3'b000;
    logic       ob;
    for (int k = 0; k < 31; k++) begin
      exp_mem[sa] = {sd, h};
      ob = sd[4];
      sd = {sd[3:0], sd[4] ^ sd[2]};
      h  = {h[1:0], ob};
      sa = {sa[3:0], sa[4] ^ sa[2]};
    end
    exp_mem[0] = 8'hA5;
  endtask

  task automatic ext_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_waddr = a; ext_wdata = d;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic ext_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    ext_raddr = a;
    @(negedge clk);
    d = rdata;
  endtask

  // Runs a test; n is the edge count from the start-sampling edge to done
  task automatic run_test(input logic chk, input int n, input logic disturb);
    bit early = 0;
    @(negedge clk);
    start = 1'b1; chk_only = chk;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; chk_only = 1'b0;
    check("R7 done cleared by start", done, 0);
    check("R7 count cleared by start", err_count, 0);
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && i == 40) begin
        start = 1'b1; ext_we = 1'b1; ext_waddr = 5'd9; ext_wdata = ~exp_mem[9];
      end
      if (disturb && i == 41) begin
        start = 1'b0; ext_we = 1'b0;
      end
      if (i < n && done) early = 1;
    end
    check("R10 done low while running", early, 0);
    check("R10 done on final edge", done, 1);
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; start = 1'b0; chk_only = 1'b0; ext_we = 1'b0;
    ext_waddr = '0; ext_raddr = '0; ext_wdata = '0;
    build_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 done after reset", done, 0);
    check("R1 fail after reset", fail, 0);
    check("R1 count after reset", err_count, 0);

    ext_write(5'd7, 8'h3C);
    ext_read(5'd7, v);
    check("R8 normal write/read", v, 8'h3C);

    // R9: mid-run write and start request must be ignored
    run_test(1'b0, 65, 1'b1);
    check("R4 fail after full test", fail, 0);
    check("R4 count after full test", err_count, 0);

    for (int a = 0; a < 32; a++) begin
      ext_read(5'(a), v);
      if (a == 0) check("R3 zero address pattern", v, exp_mem[0]);
      else if (a == 9) check("R9 ext write blocked", v, exp_mem[9]);
      else check("R2 stored word", v, exp_mem[a]);
    end

    run_test(1'b1, 33, 1'b0);
    check("R5 clean retention count", err_count, 0);
    check("R5 clean retention fail", fail, 0);

    ext_write(5'd0, 8'h00);
    ext_write(5'd4, ~exp_mem[4]);
    ext_write(5'd30, exp_mem[30] ^ 8'h01);
    run_test(1'b1, 33, 1'b0);
    check("R5 three mismatches", err_count, 3);
    check("R7 fail set", fail, 1);
    repeat (5) @(negedge clk);
    check("R7 fail held", fail, 1);

    run_test(1'b0, 65, 1'b0);
    check("R4 rerun count", err_count, 0);
    check("R7 fail cleared by rerun", fail, 0);

    for (int a = 0; a < 32; a++) ext_write(5'(a), ~exp_mem[a]);
    run_test(1'b1, 33, 1'b0);
    check("R6 saturated count", err_count, 15);
    check("R6 fail", fail, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule